// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-port, word-wide synchronous memory model with registered read data. Every control input is taken on the rising clock edge. A transfer starts when one of two address strobes is recognized while the three chip selects sample active. The host strobe has priority over the controller strobe, and a host-started access is always a read. A two-bit burst counter is loaded from the low address bits and then stepped by an advance input. Writes can cover all bytes at once or only chosen byte lanes.

The data bus is modelled as separate write-data and read-data ports plus a drive-enable output. A surrounding pad ring or test harness can turn these into a bidirectional bus. Read data leaves a pipeline register one edge after the address is taken. The drive enable follows the asynchronous output enable, except in the first read cycle after a deselect, when it is held off.

The data ports have no valid/ready handshake because the memory is always ready. A request is taken on every edge, and a caller never waits or applies back-pressure. The drive enable marks the cycles in which read data may be put on the bus.

Top module: `sync_burst_sram`

## Requirements
- R1: A controller strobe (`stb_ctl_n`=0) with chip selects active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) captures `addr`; a read at that edge returns the word at `addr`.
- R2: When both strobes are low on a selecting edge, only the host strobe acts. That access is a read, and `wr_all_n`, `wr_byte_n` and `lane_n` write nothing.
- R3: A low `stb_host_n` is ignored while `sel_a_n` is high. With `stb_ctl_n` high, an ongoing burst continues unchanged.
- R4: A recognized strobe that samples the chip selects inactive deselects the block. Nothing is written, and `drive_en` is 0 from the next cycle until the next selecting strobe.
- R5: Read data appears on `rdata` one rising edge after the address is taken.
- R6: While selected and with no strobe, `step_n`=0 increments the two-bit burst counter (3 wraps to 0). The upper address bits are unchanged, and each step accesses the new address.
- R7: While selected and with no strobe, `step_n`=1 repeats the access at the current address.
- R8: `wr_all_n`=0 writes all four bytes, whatever the values of `wr_byte_n` and `lane_n`.
- R9: With `wr_all_n`=1 and `wr_byte_n`=0, only lanes whose `lane_n` bit is 0 are written. Bit k selects `wdata[8k+7:8k]`.
- R10: With `wr_all_n`=1 and `wr_byte_n`=1, the access is a read and memory is unchanged.
- R11: `drive_en` is 1 only while `out_en_n` is 0, and it follows `out_en_n` without waiting for a clock edge.
- R12: In the cycle after a selecting read edge that follows a deselected state, `drive_en` is 0. In the next read cycle of that burst, it is 1.
- R13: During and after reset the block is deselected and `drive_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | Word address |
| stb_host_n | input | 1 | Host address strobe, active low, priority |
| stb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select, active low; also gates the host strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_byte_n | input | 1 | Byte-lane write enable, active low |
| lane_n | input | LANES | Byte-lane selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 8*LANES | Write data |
| rdata | output | 8*LANES | Registered read data |
| drive_en | output | 1 | Bus drive enable for `rdata` |

## Verification
The assertions assume that the inputs are stable at each rising edge and that `out_en_n` changes only away from the edge. The stimulus therefore changes all inputs one nanosecond after the edge. The assertions also assume that reset is applied before the first transfer. The bench holds reset for three cycles before any strobe.

The checker tracks selection with its own flag taken from the strobes and chip selects. The bench returns the block to the deselected state between scenarios, so every read scenario starts from a known masked first cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int BYTE_W = 8;

  // Lane write mask: all lanes on a global write, selected lanes on a byte write
  function automatic logic [15:0] lane_mask(input logic all_n, input logic byte_n,
                                            input logic [15:0] sel_n, input int lanes);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < lanes; i++) begin
      m[i] = !all_n || (!byte_n && !sel_n[i]);
    end
    return m;
  endfunction
endpackage

// File: rtl/sbs_addr_ctl.sv
module sbs_addr_ctl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              stb_host_n,
  input  logic              stb_ctl_n,
  input  logic              step_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              access,
  output logic              host_access,
  output logic              first_sel
);
  localparam int UP_W = ADDR_W - 2;

  logic            active_q;
  logic [UP_W-1:0] up_q;
  logic [1:0]      cnt_q;
  logic            host_rec, strobe_rec, chips_ok, selecting;

  assign host_rec   = !stb_host_n && !sel_a_n;
  assign strobe_rec = host_rec || !stb_ctl_n;
  assign chips_ok   = !sel_a_n && sel_b && !sel_c_n;
  assign selecting  = strobe_rec && chips_ok;

  always_comb begin
    if (strobe_rec)     eff_addr = addr;
    else if (!step_n)   eff_addr = {up_q, cnt_q + 2'd1};
    else                eff_addr = {up_q, cnt_q};
  end

  assign access      = selecting || (!strobe_rec && active_q);
  assign host_access = selecting && host_rec;
  assign first_sel   = selecting && !active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      up_q     <= '0;
      cnt_q    <= '0;
    end else begin
      if (strobe_rec) active_q <= chips_ok;
      if (access) {up_q, cnt_q} <= eff_addr;
    end
  end
endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                              clk,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [LANES-1:0]                  lane_we,
  input  logic                              rd_fire,
  input  logic [sbs_pkg::BYTE_W*LANES-1:0]  wdata,
  output logic [sbs_pkg::BYTE_W*LANES-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = sbs_pkg::BYTE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BW-1:0] cells [DEPTH];
    logic [BW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[l]) cells[addr] <= wdata[l*BW +: BW];
      if (rd_fire)    rd_q <= cells[addr];
    end

    assign rdata[l*BW +: BW] = rd_q;
  end
endmodule

// File: rtl/sbs_out_gate.sv
module sbs_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_fire,
  input  logic first_sel,
  input  logic out_en_n,
  output logic drive_en
);
  logic valid_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      valid_q <= rd_fire;
      mask_q  <= rd_fire && first_sel;
    end
  end

  assign drive_en = valid_q && !mask_q && !out_en_n;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              stb_host_n,
  input  logic                              stb_ctl_n,
  input  logic                              step_n,
  input  logic                              sel_a_n,
  input  logic                              sel_b,
  input  logic                              sel_c_n,
  input  logic                              wr_all_n,
  input  logic                              wr_byte_n,
  input  logic [LANES-1:0]                  lane_n,
  input  logic                              out_en_n,
  input  logic [sbs_pkg::BYTE_W*LANES-1:0]  wdata,
  output logic [sbs_pkg::BYTE_W*LANES-1:0]  rdata,
  output logic                              drive_en
);
  logic [ADDR_W-1:0] eff_addr;
  logic              access, host_access, first_sel, rd_fire;
  logic [LANES-1:0]  lane_we;
  logic [15:0]       mask_full, sel_wide;

  sbs_addr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .stb_host_n(stb_host_n), .stb_ctl_n(stb_ctl_n), .step_n(step_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .eff_addr(eff_addr), .access(access),
    .host_access(host_access), .first_sel(first_sel)
  );

  always_comb begin
    sel_wide = '1;
    sel_wide[LANES-1:0] = lane_n;
  end

  assign mask_full = sbs_pkg::lane_mask(wr_all_n, wr_byte_n, sel_wide, LANES);
  // Host-started accesses are reads; writes apply only to other accesses
  assign lane_we = (access && !host_access) ? mask_full[LANES-1:0] : '0;
  assign rd_fire = access && (lane_we == '0);

  sbs_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
    .clk(clk), .addr(eff_addr), .lane_we(lane_we), .rd_fire(rd_fire),
    .wdata(wdata), .rdata(rdata)
  );

  sbs_out_gate u_gate (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .first_sel(first_sel),
    .out_en_n(out_en_n), .drive_en(drive_en)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stb_host_n,
  input logic             stb_ctl_n,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             wr_all_n,
  input logic             wr_byte_n,
  input logic [LANES-1:0] lane_n,
  input logic             out_en_n,
  input logic             drive_en
);
  logic host_rec, rec, ok, sel_c, wr_req, rd_req;

  assign host_rec = !stb_host_n && !sel_a_n;
  assign rec      = host_rec || !stb_ctl_n;
  assign ok       = !sel_a_n && sel_b && !sel_c_n;
  assign wr_req   = !wr_all_n || (!wr_byte_n && (lane_n != {LANES{1'b1}}));
  assign rd_req   = host_rec || !wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sel_c <= 1'b0;
    else if (rec) sel_c <= ok;
  end

  // R4: deselecting strobe blanks the bus next cycle
  a_r4_desel_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && !ok) |=> !drive_en);
  // R12: first read out of deselect is masked
  a_r12_first_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && ok && !sel_c && rd_req) |=> !drive_en);
  // R8: a controller-started global write never drives the bus
  a_r8_write_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && ok && !host_rec && !wr_all_n) |=> !drive_en);
  // R13: idle and deselected keeps the bus off
  a_r13_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec && !sel_c) |=> !drive_en);
  // R5: a read inside a selected burst drives the bus when enabled
  a_r5_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && ok && sel_c && rd_req) |=> (out_en_n || drive_en));
endmodule

bind sync_burst_sram sbs_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_host_n(stb_host_n), .stb_ctl_n(stb_ctl_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_all_n(wr_all_n),
  .wr_byte_n(wr_byte_n), .lane_n(lane_n), .out_en_n(out_en_n), .drive_en(drive_en)
);

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;
  localparam int AW = 10;
  localparam int LN = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic stb_host_n, stb_ctl_n, step_n, sel_a_n, sel_b, sel_c_n;
  logic wr_all_n, wr_byte_n, out_en_n;
  logic [LN-1:0] lane_n;
  logic [31:0] wdata, rdata;
  logic drive_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] ref_m [1 << AW];

  always #2.5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .stb_host_n(stb_host_n),
    .stb_ctl_n(stb_ctl_n), .step_n(step_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_n(lane_n), .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata),
    .drive_en(drive_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle_in();
    stb_host_n = 1; stb_ctl_n = 1; step_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    wr_all_n = 1; wr_byte_n = 1; lane_n = '1; out_en_n = 0; wdata = '0;
  endtask

  task automatic desel();
    stb_ctl_n = 0; sel_b = 0; cyc(); idle_in();
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] ln);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (!ln[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic wr_glob(input logic [AW-1:0] a, input logic [31:0] d);
    stb_ctl_n = 0; addr = a; wdata = d; wr_all_n = 0; wr_byte_n = 1; lane_n = 4'b0110;
    cyc(); idle_in(); desel();
    ref_m[a] = d;
  endtask

  // Controller-strobe read from deselected: masked cycle then driven repeat
  task automatic rd_chk(input logic [AW-1:0] a, input string tag);
    stb_ctl_n = 0; addr = a; cyc(); idle_in();
    chk({tag, " masked drive"}, {31'b0, drive_en}, 32'd0);
    chk({tag, " data"}, rdata, ref_m[a]);
    cyc();
    chk({tag, " driven"}, {31'b0, drive_en}, 32'd1);
    chk({tag, " repeat"}, rdata, ref_m[a]);
    desel();
  endtask

  task automatic t_reset();
    rst_n = 0; idle_in(); addr = '0;
    repeat (3) cyc();
    chk("R13 reset drive", {31'b0, drive_en}, 32'd0);
    rst_n = 1; cyc();
    chk("R13 idle after reset", {31'b0, drive_en}, 32'd0);
  endtask

  task automatic t_global();
    wr_glob(10'h040, 32'hA1B2C3D4);
    rd_chk(10'h040, "R8 R1 R5 R12");
  endtask

  task automatic t_bytes();
    wr_glob(10'h081, 32'h11223344);
    stb_ctl_n = 0; addr = 10'h081; wdata = 32'hEEDDCCBB; wr_byte_n = 0; lane_n = 4'b1010;
    cyc(); idle_in(); desel();
    ref_m[10'h081] = merge(ref_m[10'h081], 32'hEEDDCCBB, 4'b1010);
    chk("R9 lane model", ref_m[10'h081], 32'h11DD33BB);
    rd_chk(10'h081, "R9");
    stb_ctl_n = 0; addr = 10'h081; wdata = 32'h0; cyc(); idle_in(); desel();
    rd_chk(10'h081, "R10");
  endtask

  task automatic t_burst();
    for (int i = 0; i < 4; i++) wr_glob(10'h100 + i, 32'h5000_0000 + i);
    wr_glob(10'h104, 32'hDEAD0004);
    stb_ctl_n = 0; addr = 10'h102; cyc(); idle_in();
    chk("R12 burst first masked", {31'b0, drive_en}, 32'd0);
    chk("R5 burst first data", rdata, ref_m[10'h102]);
    step_n = 0; cyc();
    chk("R6 step to 3", rdata, ref_m[10'h103]);
    chk("R12 burst driven", {31'b0, drive_en}, 32'd1);
    cyc(); chk("R6 wrap to 0", rdata, ref_m[10'h100]);
    cyc(); chk("R6 step to 1", rdata, ref_m[10'h101]);
    step_n = 1; cyc(); chk("R7 hold", rdata, ref_m[10'h101]);
    out_en_n = 1; #0.5;
    chk("R11 oe off", {31'b0, drive_en}, 32'd0);
    out_en_n = 0; #0.5;
    chk("R11 oe on", {31'b0, drive_en}, 32'd1);
    stb_host_n = 0; sel_a_n = 1; cyc();
    chk("R3 host ignored data", rdata, ref_m[10'h101]);
    chk("R3 host ignored drive", {31'b0, drive_en}, 32'd1);
    idle_in(); desel();
    chk("R4 deselect drive", {31'b0, drive_en}, 32'd0);
  endtask

  task automatic t_priority();
    wr_glob(10'h200, 32'hCAFE0200);
    stb_host_n = 0; stb_ctl_n = 0; addr = 10'h200; wdata = 32'h0BAD0BAD;
    wr_all_n = 0; wr_byte_n = 0; lane_n = '0;
    cyc(); idle_in();
    chk("R2 host read data", rdata, ref_m[10'h200]);
    chk("R2 host first masked", {31'b0, drive_en}, 32'd0);
    desel();
    rd_chk(10'h200, "R2 unchanged");
  endtask

  task automatic t_desel_write();
    wr_glob(10'h300, 32'h3000_0300);
    stb_ctl_n = 0; sel_c_n = 1; addr = 10'h300; wdata = 32'hFFFF_FFFF; wr_all_n = 0;
    cyc(); idle_in();
    chk("R4 deselect no drive", {31'b0, drive_en}, 32'd0);
    cyc();
    chk("R4 stays off", {31'b0, drive_en}, 32'd0);
    rd_chk(10'h300, "R4 no write");
  endtask

  initial begin
    t_reset();
    t_global();
    t_bytes();
    t_burst();
    t_priority();
    t_desel_write();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule